// File: doc/BRIEF.md
# Lane-Partitioned Vector Multiply-Accumulate with Scalar Broadcast

This block performs one vector multiply-accumulate step on a 128-bit datapath. It takes an accumulator vector, a source vector and a 32-bit scalar. For every lane it adds the product of the source lane and the scalar to the accumulator lane. The result is registered and returned as the new accumulator vector. A shared element-size select splits both vectors into sixteen 8-bit lanes, eight 16-bit lanes or four 32-bit lanes. The same scalar value is broadcast to every lane.

A predicate mask with one bit per byte enables or disables each lane. Disabled lanes pass their old accumulator value through unchanged. This is how a loop whose element count is not a multiple of the lane count handles its last, partly filled step. A one-cycle start pulse loads the result register, and a valid flag marks the cycle in which the new result appears.

Top module: `vmac_top`

## Requirements
- R1: `elemSize` selects the lane layout. The value 0 gives sixteen 8-bit lanes, 1 gives eight 16-bit lanes, 2 gives four 32-bit lanes, and 3 behaves like 2. Lane k occupies bits [k*W+W-1 : k*W], where W is the lane width.
- R2: Each enabled lane k produces accIn lane k plus (srcIn lane k times the scalar).
- R3: Every lane uses the same scalar, and only its low W bits, `scalarIn[W-1:0]`, take part in the product. The upper scalar bits have no effect.
- R4: Each lane result is kept to W bits, so it wraps modulo 2^W. No carry or product bit crosses into a neighbouring lane.
- R5: `laneMask` has one bit per byte. Lane k is enabled when `laneMask[k*W/8]` is 1. A disabled lane outputs its accIn value, and the other mask bits of its bytes are ignored.
- R6: When `start` is high at a rising clock edge, `resultOut` shows that cycle's result after the edge and `validOut` is 1. After any edge with `start` low, `validOut` is 0.
- R7: While `start` is low, `resultOut` holds its last value regardless of the other inputs.
- R8: Synchronous reset (`rst` high at an edge) clears `validOut` and `resultOut` to 0.
- R9: In 32-bit mode with accumulator lanes {7,1,6,2}, source lanes {5,2,3,6} (lane 0 first), scalar 2 and all lanes enabled, the result lanes are {17,5,12,14}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; loads the result register |
| elemSize | input | 2 | Lane width select (0: 8, 1: 16, 2 or 3: 32 bits) |
| accIn | input | 128 | Accumulator vector |
| srcIn | input | 128 | Source vector |
| scalarIn | input | 32 | Broadcast scalar |
| laneMask | input | 16 | Per-byte predicate bits |
| resultOut | output | 128 | Registered new accumulator vector |
| validOut | output | 1 | High for the cycle after a start |

## Verification
The hardest condition to reach from the ports is a lane that is disabled even though some of its bytes have their mask bit set. The bench must show that only the lowest byte's bit decides. It also needs a lane that wraps while its neighbour carries a visible value, which proves no carry leaks across the boundary.

Directed cases cover both situations:
- a 32-bit-mode mask such as 0xFFFE, which disables only lane 0;
- 8-bit and 16-bit all-ones accumulators incremented by one;
- a scalar whose upper bits are nonzero.

Random operations with random masks and sizes, including the value 3 for `elemSize`, then cover the other combinations.

// File: rtl/vmac_pkg.sv
package vmac_pkg;
  localparam int VEC_W    = 128;
  localparam int SCALAR_W = 32;
  localparam int MASK_W   = VEC_W / 8;

  typedef enum logic [1:0] {
    SZ_B8  = 2'd0,
    SZ_B16 = 2'd1,
    SZ_B32 = 2'd2,
    SZ_RSV = 2'd3
  } elemSize_e;

  typedef struct packed {
    logic load;
    logic clear;
  } ctrlStrobe_t;
endpackage

// File: rtl/vmac_lane.sv
module vmac_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] accLane,
  input  logic [W-1:0] srcLane,
  input  logic [W-1:0] scalarLow,
  input  logic         laneEn,
  output logic [W-1:0] laneOut
);
  logic [W-1:0] prodLow;
  logic [W-1:0] sumLow;

  // products and sums are kept to W bits: modulo 2^W, no spill to neighbours
  assign prodLow = srcLane * scalarLow;
  assign sumLow  = accLane + prodLow;
  assign laneOut = laneEn ? sumLow : accLane;
endmodule

// File: rtl/vmac_ctrl.sv
module vmac_ctrl
  import vmac_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output ctrlStrobe_t strobe,
  output logic        validOut
);
  assign strobe.load  = start & ~rst;
  assign strobe.clear = rst;

  always_ff @(posedge clk) begin
    if (rst) validOut <= 1'b0;
    else     validOut <= start;
  end

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start |=> validOut); // R6
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !start |=> !validOut); // R6
endmodule

// File: rtl/vmac_datapath.sv
module vmac_datapath
  import vmac_pkg::*;
#(
  parameter int VW = VEC_W,
  parameter int SW = SCALAR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [1:0]        elemSize,
  input  logic [VW-1:0]     accIn,
  input  logic [VW-1:0]     srcIn,
  input  logic [SW-1:0]     scalarIn,
  input  logic [VW/8-1:0]   laneMask,
  output logic [VW-1:0]     resultOut
);
  localparam int N8  = VW / 8;
  localparam int N16 = VW / 16;
  localparam int N32 = VW / 32;

  logic [VW-1:0] res8, res16, res32, nextRes;

  for (genvar k = 0; k < N8; k++) begin : g_b8
    vmac_lane #(.W(8)) u_lane (
      .accLane(accIn[k*8 +: 8]), .srcLane(srcIn[k*8 +: 8]),
      .scalarLow(scalarIn[7:0]), .laneEn(laneMask[k]),
      .laneOut(res8[k*8 +: 8]));
  end
  for (genvar k = 0; k < N16; k++) begin : g_b16
    vmac_lane #(.W(16)) u_lane (
      .accLane(accIn[k*16 +: 16]), .srcLane(srcIn[k*16 +: 16]),
      .scalarLow(scalarIn[15:0]), .laneEn(laneMask[k*2]),
      .laneOut(res16[k*16 +: 16]));
  end
  for (genvar k = 0; k < N32; k++) begin : g_b32
    vmac_lane #(.W(32)) u_lane (
      .accLane(accIn[k*32 +: 32]), .srcLane(srcIn[k*32 +: 32]),
      .scalarLow(scalarIn[31:0]), .laneEn(laneMask[k*4]),
      .laneOut(res32[k*32 +: 32]));
  end

  always_comb begin
    unique case (elemSize_e'(elemSize))
      SZ_B8:   nextRes = res8;
      SZ_B16:  nextRes = res16;
      default: nextRes = res32;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobe.clear)     resultOut <= '0;
    else if (strobe.load) resultOut <= nextRes;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> $stable(resultOut)); // R7
  AST_MASKED_LANE0_KEEP: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && elemSize[1] && !laneMask[0]) |=>
      resultOut[31:0] == $past(accIn[31:0])); // R5
  AST_B8_LANE0_SUM: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && elemSize == 2'd0 && laneMask[0]) |=>
      resultOut[7:0] == 8'($past(accIn[7:0]) + $past(srcIn[7:0]) * $past(scalarIn[7:0]))); // R4
endmodule

// File: rtl/vmac_top.sv
module vmac_top
  import vmac_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [1:0]          elemSize,
  input  logic [VEC_W-1:0]    accIn,
  input  logic [VEC_W-1:0]    srcIn,
  input  logic [SCALAR_W-1:0] scalarIn,
  input  logic [MASK_W-1:0]   laneMask,
  output logic [VEC_W-1:0]    resultOut,
  output logic                validOut
);
  ctrlStrobe_t strobe;

  vmac_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .strobe(strobe), .validOut(validOut));

  vmac_datapath #(.VW(VEC_W), .SW(SCALAR_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .elemSize(elemSize),
    .accIn(accIn), .srcIn(srcIn), .scalarIn(scalarIn), .laneMask(laneMask),
    .resultOut(resultOut));

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!validOut && resultOut == '0)); // R8
endmodule

// File: tb/vmac_top_tb.sv
module vmac_top_tb;
  logic clk = 0;
  logic rst, start;
  logic [1:0] elemSize;
  logic [127:0] accIn, srcIn, resultOut;
  logic [31:0] scalarIn;
  logic [15:0] laneMask;
  logic validOut;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vmac_top u_dut (.clk(clk), .rst(rst), .start(start), .elemSize(elemSize),
    .accIn(accIn), .srcIn(srcIn), .scalarIn(scalarIn), .laneMask(laneMask),
    .resultOut(resultOut), .validOut(validOut));

  function automatic logic [127:0] refMac(logic [127:0] a, logic [127:0] s,
      logic [31:0] sc, logic [1:0] sz, logic [15:0] m);
    int w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    logic [127:0] lm = (128'd1 << w) - 128'd1;
    logic [127:0] r = a;
    for (int l = 0; l < 128 / w; l++) begin
      if (m[l * w / 8]) begin
        logic [127:0] av = (a >> (l * w)) & lm;
        logic [127:0] sv = (s >> (l * w)) & lm;
        logic [127:0] kv = {96'd0, sc} & lm;
        logic [127:0] nv = (av + sv * kv) & lm;
        r = (r & ~(lm << (l * w))) | (nv << (l * w));
      end
    end
    return r;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(string req, logic [1:0] sz, logic [127:0] a,
      logic [127:0] s, logic [31:0] sc, logic [15:0] m, logic [127:0] exp);
    @(negedge clk);
    elemSize = sz; accIn = a; srcIn = s; scalarIn = sc; laneMask = m; start = 1;
    @(negedge clk);
    start = 0;
    check(req, resultOut, exp);
    check({req, " valid R6"}, {127'd0, validOut}, 128'd1);
  endtask

  task automatic idleCheck();
    logic [127:0] held = resultOut;
    @(negedge clk);
    accIn = {$urandom, $urandom, $urandom, $urandom};
    srcIn = {$urandom, $urandom, $urandom, $urandom};
    scalarIn = $urandom; laneMask = 16'($urandom);
    @(negedge clk);
    check("R7 hold", resultOut, held);
    check("R6 valid low", {127'd0, validOut}, 128'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] a, s, e;
    logic [31:0] sc;
    logic [15:0] m;
    logic [1:0] sz;
    void'($urandom(32'd1234));
    rst = 1; start = 0; elemSize = 0; accIn = '1; srcIn = '1; scalarIn = '1; laneMask = '1;
    repeat (3) @(negedge clk);
    check("R8 reset result", resultOut, 128'd0);
    check("R8 reset valid", {127'd0, validOut}, 128'd0);
    rst = 0;

    // R9 example
    runOp("R9", 2'd2, {32'd2, 32'd6, 32'd1, 32'd7}, {32'd6, 32'd3, 32'd2, 32'd5},
          32'd2, 16'hFFFF, {32'd14, 32'd12, 32'd5, 32'd17});
    idleCheck();
    // R4 8-bit wrap, neighbour lane untouched
    runOp("R4 b8 wrap", 2'd0, {112'd0, 8'h10, 8'hFF}, {112'd0, 8'h00, 8'h01},
          32'd1, 16'hFFFF, {112'd0, 8'h10, 8'h00});
    // R4 16-bit wrap
    runOp("R4 b16 wrap", 2'd1, {96'd0, 16'h0003, 16'hFFFF}, {96'd0, 16'h0000, 16'h0001},
          32'd1, 16'hFFFF, {96'd0, 16'h0003, 16'h0000});
    // R3 upper scalar bits ignored in 8-bit mode
    runOp("R3 scalar low bits", 2'd0, {120'd0, 8'd3}, {120'd0, 8'd4},
          32'hFFFFFF02, 16'hFFFF, {120'd0, 8'd11});
    // R5 lane0 disabled despite upper byte bits set (32-bit)
    a = {32'd1, 32'd2, 32'd3, 32'd4}; s = {32'd1, 32'd1, 32'd1, 32'd1};
    runOp("R5 lowest-byte bit", 2'd2, a, s, 32'd10, 16'hFFFE,
          {32'd11, 32'd12, 32'd13, 32'd4});
    // R5 only lane0 bit set (32-bit) -> only lane0 updates
    runOp("R5 single lane", 2'd2, a, s, 32'd10, 16'h0001,
          {32'd1, 32'd2, 32'd3, 32'd14});
    // R5 all disabled
    runOp("R5 mask zero", 2'd0, a, s, 32'd7, 16'h0000, a);
    // R1 elemSize 3 behaves as 32-bit
    runOp("R1 size3", 2'd3, {96'd0, 32'h0000_00FF}, {96'd0, 32'd1}, 32'd1, 16'hFFFF,
          {96'd0, 32'h0000_0100});
    idleCheck();

    for (int i = 0; i < 200; i++) begin
      a = {$urandom, $urandom, $urandom, $urandom};
      s = {$urandom, $urandom, $urandom, $urandom};
      sc = $urandom; m = 16'($urandom); sz = 2'($urandom);
      e = refMac(a, s, sc, sz, m);
      runOp("R2 random", sz, a, s, sc, m, e);
      if (i % 20 == 0) idleCheck();
    end

    // R8 reset mid-stream
    @(negedge clk); rst = 1; start = 1;
    @(negedge clk); rst = 0; start = 0;
    check("R8 reset clears", resultOut, 128'd0);
    check("R8 reset valid", {127'd0, validOut}, 128'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule